// File: doc/BRIEF.md
# ADC Sample Sequencer Result FIFOs

This block is the digital back end of a four-sequencer analog-to-digital converter. The conversion itself lives elsewhere. Each sequencer owns a 16-entry result FIFO. The FIFO's read pointer, write pointer, empty flag and full flag are packed into one status word that software can read at any time.

A conversion trigger, such as a timer pulse, is accepted only while sequencer 0 is enabled. An accepted trigger pushes one result into sequencer 0's FIFO and raises raw interrupt bit 0. The result comes from the `sample_in` port. When the `USE_PRNG` parameter is set, it comes instead from a built-in pseudo-random generator.

Software reaches the block over a simple register bus. Reading a sequencer's data register pops its FIFO in the same cycle. The interrupt output is the OR of the raw interrupt bits that the mask enables.

Top module: `adc_seq_fifo_top`

## Requirements
- R1: After reset every sequencer status word reads 0x100. The enable, mask, raw-interrupt, input-mux and control registers all read 0, and `irq` is low.
- R2: Status word layout:
  - bits 3:0 hold the read pointer;
  - bits 7:4 hold the write pointer;
  - bit 8 is EMPTY;
  - bit 12 is FULL;
  - all other bits read 0;
  - EMPTY and FULL are never both set.
- R3: A pop of a non-empty FIFO returns the oldest entry and advances the read pointer modulo 16. It clears FULL. It sets EMPTY when the new read pointer equals the write pointer.
- R4: A push stores at the write pointer, advances the write pointer modulo 16 and clears EMPTY. It sets FULL when the new write pointer equals the read pointer. A push into a full FIFO is dropped and leaves the status unchanged.
- R5: A trigger while bit 0 of the enable register is clear changes no FIFO and no raw bit. Otherwise it pushes one sample into FIFO 0 only and sets raw bit 0, even when that push is dropped.
- R6: `irq` is high exactly when (raw & mask) is nonzero.
  - Offset 0x08 reads raw & mask.
  - Writing ones to offset 0x0C clears the matching raw bits.
  - A trigger in the same cycle as a clear of bit 0 leaves bit 0 set.
- R7: Register field widths:
  - the enable register (0x00) and the mask register (0x10) keep only bits 3:0;
  - each input-mux register keeps only the bits selected by 0x33333333;
  - control registers keep all 32 bits.
- R8: Address map:
  - offset 0x04 reads the raw interrupt bits;
  - sequencer n's window starts at 0x40 + 32·n, with input mux at +0x00, control at +0x04, FIFO data at +0x08 (a read pops) and FIFO status at +0x0C.
- R9: Reading the data register of an empty FIFO returns 0 and leaves its pointers and flags unchanged.
- R10: A pop and a push in the same cycle are both performed. This holds on a full FIFO, where the pop frees the slot and FULL stays set. It also holds on an empty FIFO, where the read returns 0 and the push lands.
- R11: With `USE_PRNG`=1, each accepted trigger first updates a 32-bit state that starts at 0, as state = state·314159 + 1. The sample pushed is then 0x200 + ((state >> 16) & 7).
- R12: With `USE_PRNG`=0 the sample pushed is `sample_in`. It is read back zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops a FIFO when it addresses a data register |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| trig | input | 1 | Conversion trigger pulse, one cycle per sample |
| sample_in | input | SAMPLE_W | Conversion result used when the generator is not built |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the simultaneous push and pop, on a full FIFO and on an empty one. Only a trigger can push, and it must coincide with a bus read of data register 0. The stimulus therefore first drives sixteen accepted triggers to reach FULL, and drains the FIFO later to reach EMPTY. At each of those points it issues the trigger and the read in the same cycle.

A second instance built with the generator shares the bus and triggers. Its popped values are compared against a state sequence that the bench computes on its own.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int FIFO_DEPTH = 16;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int EMPTY_BIT  = 8;
  localparam int FULL_BIT   = 12;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  // Pack pointers and flags into the software-visible status word.
  function automatic logic [31:0] pack_status(input logic [PTR_W-1:0] rp,
                                              input logic [PTR_W-1:0] wp,
                                              input logic             emp,
                                              input logic             ful);
    logic [31:0] s;
    s            = '0;
    s[3:0]       = 4'(rp);
    s[7:4]       = 4'(wp);
    s[EMPTY_BIT] = emp;
    s[FULL_BIT]  = ful;
    return s;
  endfunction

  // Linear congruential step used by the optional sample generator.
  function automatic logic [31:0] lcg_next(input logic [31:0] s);
    return s * 32'd314159 + 32'd1;
  endfunction

  function automatic logic [31:0] lcg_sample(input logic [31:0] s);
    return 32'h200 + {29'd0, s[18:16]};
  endfunction

endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [31:0]       status_o
);

  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  rptr, wptr;
  logic              empty, full;
  logic              do_pop, do_push;
  logic [PTR_W-1:0]  rptr_n, wptr_n;

  // A pop on empty is void; a pop in the same cycle frees room for a push.
  assign do_pop  = pop_i & ~empty;
  assign do_push = push_i & (~full | do_pop);
  assign rptr_n  = do_pop  ? ptr_next(rptr) : rptr;
  assign wptr_n  = do_push ? ptr_next(wptr) : wptr;

  assign pop_data_o = empty ? '0 : mem[rptr];
  assign status_o   = pack_status(rptr, wptr, empty, full);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      rptr <= rptr_n;
      wptr <= wptr_n;
      if (do_push && !do_pop) begin
        empty <= 1'b0;
        full  <= (wptr_n == rptr);
      end else if (do_pop && !do_push) begin
        full  <= 1'b0;
        empty <= (rptr_n == wptr);
      end
    end
  end

endmodule

// File: rtl/adc_seq_prng.sv
module adc_seq_prng
  import adc_seq_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  output logic [SAMPLE_W-1:0] sample_o
);

  logic [31:0] state;
  logic [31:0] state_n;

  assign state_n  = lcg_next(state);
  assign sample_o = SAMPLE_W'(lcg_sample(state_n));

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= '0;
    else if (step_i) state <= state_n;
  end

endmodule

// File: rtl/adc_seq_fifo_top.sv
module adc_seq_fifo_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_SEQ  = 4,
  parameter int SAMPLE_W = 10,
  parameter bit USE_PRNG = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                trig,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                irq
);

  localparam int          SEL_W    = $clog2(NUM_SEQ);
  localparam logic [31:0] MUX_KEEP = 32'h3333_3333;

  logic [3:0]  active_q, mask_q, raw_q;
  logic [31:0] mux_q [NUM_SEQ];
  logic [31:0] ctl_q [NUM_SEQ];

  logic              in_win;
  logic [6:0]        win_off;
  logic [SEL_W-1:0]  win_sel;
  logic [4:0]        win_reg;
  logic              trig_ok;
  logic [3:0]        clr_bits;
  logic [SAMPLE_W-1:0] sample_sel;

  logic [SAMPLE_W-1:0] fifo_dout [NUM_SEQ];
  logic [31:0]         fifo_stat [NUM_SEQ];
  logic [NUM_SEQ-1:0]  fifo_pop;

  // Named internal events for the bound checker.
  logic             push_ev0, pop_ev0, f0_empty, f0_full;
  logic [PTR_W-1:0] f0_wptr, f0_rptr;

  assign in_win  = (bus_addr >= 8'h40) && (bus_addr < 8'hC0);
  assign win_off = bus_addr[6:0] - 7'h40;
  assign win_sel = win_off[5 +: SEL_W];
  assign win_reg = win_off[4:0];
  assign trig_ok = trig & active_q[0];

  generate
    if (USE_PRNG) begin : g_prng
      logic unused_sample_in;
      assign unused_sample_in = ^sample_in;
      adc_seq_prng #(.SAMPLE_W(SAMPLE_W)) u_prng (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (trig_ok),
        .sample_o(sample_sel)
      );
    end else begin : g_port
      assign sample_sel = sample_in;
    end
  endgenerate

  generate
    for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
      assign fifo_pop[n] = bus_rd & in_win & (win_sel == SEL_W'(n)) & (win_reg == 5'h08);
      adc_seq_fifo #(.DATA_W(SAMPLE_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     ((n == 0) ? trig_ok : 1'b0),
        .push_data_i(sample_sel),
        .pop_i      (fifo_pop[n]),
        .pop_data_o (fifo_dout[n]),
        .status_o   (fifo_stat[n])
      );
    end
  endgenerate

  assign push_ev0 = trig_ok;
  assign pop_ev0  = fifo_pop[0];
  assign f0_rptr  = fifo_stat[0][3:0];
  assign f0_wptr  = fifo_stat[0][7:4];
  assign f0_empty = fifo_stat[0][EMPTY_BIT];
  assign f0_full  = fifo_stat[0][FULL_BIT];

  assign clr_bits = (bus_wr && !in_win && bus_addr == 8'h0C) ? bus_wdata[3:0] : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
      for (int n = 0; n < NUM_SEQ; n++) begin
        mux_q[n] <= '0;
        ctl_q[n] <= '0;
      end
    end else begin
      raw_q <= (raw_q & ~clr_bits) | {3'b000, trig_ok};
      if (bus_wr) begin
        if (in_win) begin
          if (win_reg == 5'h00) mux_q[win_sel] <= bus_wdata & MUX_KEEP;
          if (win_reg == 5'h04) ctl_q[win_sel] <= bus_wdata;
        end else begin
          if (bus_addr == 8'h00) active_q <= bus_wdata[3:0];
          if (bus_addr == 8'h10) mask_q   <= bus_wdata[3:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      case (win_reg)
        5'h00:   bus_rdata = mux_q[win_sel];
        5'h04:   bus_rdata = ctl_q[win_sel];
        5'h08:   bus_rdata = 32'(fifo_dout[win_sel]);
        5'h0C:   bus_rdata = fifo_stat[win_sel];
        default: bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        8'h00:   bus_rdata = {28'd0, active_q};
        8'h04:   bus_rdata = {28'd0, raw_q};
        8'h08:   bus_rdata = {28'd0, raw_q & mask_q};
        8'h10:   bus_rdata = {28'd0, mask_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(raw_q & mask_q);

endmodule

// File: rtl/adc_seq_fifo_chk.sv
module adc_seq_fifo_chk
  import adc_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             active0,
  input logic             raw0,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             f_empty,
  input logic             f_full,
  input logic [PTR_W-1:0] f_wptr,
  input logic [PTR_W-1:0] f_rptr
);

  p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_empty && f_full));

  p_empty_means_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f_empty |-> (f_wptr == f_rptr));

  p_push_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> !f_empty);

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_full && push_ev && !pop_ev) |=> ($stable(f_wptr) && f_full));

  p_idle_trigger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !active0) |=> $stable(f_wptr));

  p_trigger_sets_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && active0) |=> raw0);

  p_empty_pop_void_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (f_empty && pop_ev && !push_ev) |=> ($stable(f_rptr) && f_empty));

endmodule

bind adc_seq_fifo_top adc_seq_fifo_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .trig   (trig),
  .active0(active_q[0]),
  .raw0   (raw_q[0]),
  .push_ev(push_ev0),
  .pop_ev (pop_ev0),
  .f_empty(f0_empty),
  .f_full (f0_full),
  .f_wptr (f0_wptr),
  .f_rptr (f0_rptr)
);

// File: tb/test_adc_seq_fifo_top.sv
`timescale 1ns/1ps
module test_adc_seq_fifo_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, trig = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [9:0]  sample_in = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_seq_fifo_top #(.USE_PRNG(1'b0)) i_adc_seq_fifo_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .trig(trig), .sample_in(sample_in), .irq(irq_a));

  adc_seq_fifo_top #(.USE_PRNG(1'b1)) i_adc_seq_fifo_top_prng (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .trig(trig), .sample_in(sample_in), .irq(irq_b));

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [9:0]  smp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TRIG = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   8'h4C, 32'h0000_0100, 10'h000, 4'd1},  // R1 status after reset
    '{OP_RD,   8'h00, 32'h0000_0000, 10'h000, 4'd1},  // R1 enable clear
    '{OP_IRQ,  8'h00, 32'h0000_0000, 10'h000, 4'd1},  // R1 irq low
    '{OP_TRIG, 8'h00, 32'h0000_0000, 10'h0AA, 4'd5},  // R5 trigger while disabled
    '{OP_RD,   8'h4C, 32'h0000_0100, 10'h000, 4'd5},  // R5 nothing pushed
    '{OP_RD,   8'h04, 32'h0000_0000, 10'h000, 4'd5},  // R5 raw untouched
    '{OP_WR,   8'h00, 32'h0000_00FF, 10'h000, 4'd7},
    '{OP_RD,   8'h00, 32'h0000_000F, 10'h000, 4'd7},  // R7 enable keeps 4 bits
    '{OP_WR,   8'h40, 32'hFFFF_FFFF, 10'h000, 4'd7},
    '{OP_RD,   8'h40, 32'h3333_3333, 10'h000, 4'd7},  // R7 mux masked
    '{OP_TRIG, 8'h00, 32'h0000_0000, 10'h155, 4'd4},
    '{OP_RD,   8'h4C, 32'h0000_0010, 10'h000, 4'd2},  // R2 wptr in bits 7:4
    '{OP_RD,   8'h04, 32'h0000_0001, 10'h000, 4'd5},  // R5 raw bit 0
    '{OP_RD,   8'h08, 32'h0000_0000, 10'h000, 4'd6},  // R6 masked read, mask 0
    '{OP_IRQ,  8'h00, 32'h0000_0000, 10'h000, 4'd6},  // R6 irq off while masked
    '{OP_WR,   8'h10, 32'h0000_00FF, 10'h000, 4'd7},
    '{OP_RD,   8'h10, 32'h0000_000F, 10'h000, 4'd7},  // R7 mask keeps 4 bits
    '{OP_RD,   8'h08, 32'h0000_0001, 10'h000, 4'd6},  // R6 masked read
    '{OP_IRQ,  8'h00, 32'h0000_0001, 10'h000, 4'd6},  // R6 irq on
    '{OP_RD,   8'h48, 32'h0000_0155, 10'h000, 4'd12}, // R12 sample, pops
    '{OP_RD,   8'h4C, 32'h0000_0111, 10'h000, 4'd3},  // R3 empty, rptr 1
    '{OP_RD,   8'h48, 32'h0000_0000, 10'h000, 4'd9},  // R9 empty read is 0
    '{OP_RD,   8'h4C, 32'h0000_0111, 10'h000, 4'd9},  // R9 pointers kept
    '{OP_RD,   8'h6C, 32'h0000_0100, 10'h000, 4'd8}   // R8 sequencer 1 status untouched
  };

  // Bench model of FIFO 0, by count, and of the generator.
  int          q_smp [$];
  int          q_prn [$];
  int          bm_r = 1, bm_w = 1;
  logic [31:0] prng_st = 32'd1;  // one accepted trigger occurred in the table

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic wr, input logic rd, input logic tg, input logic [7:0] a,
                           input logic [31:0] d, input logic [9:0] s,
                           output logic [31:0] ra, output logic [31:0] rb);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; trig = tg; bus_addr = a; bus_wdata = d; sample_in = s;
    #1;
    ra = rdata_a; rb = rdata_b;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; trig = 1'b0;
  endtask

  function automatic logic [31:0] exp_status();
    return ((q_smp.size() == 16) ? 32'h1000 : 32'h0) | ((q_smp.size() == 0) ? 32'h100 : 32'h0) |
           32'(bm_w << 4) | 32'(bm_r);
  endfunction

  // One cycle on FIFO 0 with optional accepted trigger and pop, then a status read.
  task automatic fifo_op(input string tag, input bit push, input bit pop, input int smp);
    logic [31:0] ra, rb, ea, eb;
    bit dpop, dpush;
    ea = (q_smp.size() > 0) ? 32'(q_smp[0]) : 32'h0;
    eb = (q_prn.size() > 0) ? 32'(q_prn[0]) : 32'h0;
    bus_cycle(1'b0, pop, push, pop ? 8'h48 : 8'h4C, 32'h0, 10'(smp), ra, rb);
    if (pop) begin
      check({tag, " R12 data"}, ra, ea);
      check({tag, " R11 generator data"}, rb, eb);
    end
    dpop  = pop && (q_smp.size() > 0);
    dpush = push && ((q_smp.size() < 16) || dpop);
    if (push) prng_st = prng_st * 32'd314159 + 32'd1;
    if (dpop) begin
      void'(q_smp.pop_front()); void'(q_prn.pop_front());
      bm_r = (bm_r + 1) % 16;
    end
    if (dpush) begin
      q_smp.push_back(smp & 10'h3FF);
      q_prn.push_back(32'h200 + ((prng_st >> 16) & 32'h7));
      bm_w = (bm_w + 1) % 16;
    end
    bus_cycle(1'b0, 1'b0, 1'b0, 8'h4C, 32'h0, 10'h0, ra, rb);
    check({tag, " status"}, ra, exp_status());
    check({tag, " generator status"}, rb, exp_status());
  endtask

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_report();
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   bus_cycle(1'b1, 1'b0, 1'b0, VECS[i].addr, VECS[i].data, VECS[i].smp, ra, rb);
        OP_TRIG: bus_cycle(1'b0, 1'b0, 1'b1, VECS[i].addr, VECS[i].data, VECS[i].smp, ra, rb);
        OP_RD: begin
          bus_cycle(1'b0, 1'b1, 1'b0, VECS[i].addr, VECS[i].data, VECS[i].smp, ra, rb);
          check($sformatf("R%0d vector %0d", VECS[i].req, i), ra, VECS[i].data);
        end
        default: begin
          @(negedge clk); #1;
          check($sformatf("R%0d vector %0d irq", VECS[i].req, i), 32'(irq_a), VECS[i].data);
        end
      endcase
    end

    // R4: fill FIFO 0 to FULL (wraps write pointer), then a dropped push.
    for (int k = 0; k < 16; k++) fifo_op("R4 fill", 1'b1, 1'b0, 10'h100 + k);
    fifo_op("R4 drop when full", 1'b1, 1'b0, 10'h3FF);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h04, 32'h0, 10'h0, ra, rb);
    check("R5 raw set on dropped push", ra, 32'h1);
    @(negedge clk); #1;
    check("R6 irq with raw and mask", 32'(irq_a), 32'h1);

    // R3 pop from full, R10 push+pop on full.
    fifo_op("R3 pop from full", 1'b0, 1'b1, 0);
    fifo_op("R4 refill", 1'b1, 1'b0, 10'h2A5);
    fifo_op("R10 push and pop while full", 1'b1, 1'b1, 10'h05A);

    // R3 drain to empty, checking order; R9 empty pop; R10 push+pop on empty.
    for (int k = 0; k < 16; k++) fifo_op("R3 drain", 1'b0, 1'b1, 0);
    fifo_op("R9 pop on empty", 1'b0, 1'b1, 0);
    fifo_op("R10 push and pop while empty", 1'b1, 1'b1, 10'h0C3);
    fifo_op("R3 final pop", 1'b0, 1'b1, 0);

    // R6: clear and trigger in the same cycle, then clear alone.
    bus_cycle(1'b1, 1'b0, 1'b1, 8'h0C, 32'hF, 10'h011, ra, rb);
    q_smp.push_back(10'h011); bm_w = (bm_w + 1) % 16;
    prng_st = prng_st * 32'd314159 + 32'd1;
    q_prn.push_back(32'h200 + ((prng_st >> 16) & 32'h7));
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h04, 32'h0, 10'h0, ra, rb);
    check("R6 set wins over clear", ra, 32'h1);
    bus_cycle(1'b1, 1'b0, 1'b0, 8'h0C, 32'h1, 10'h0, ra, rb);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h04, 32'h0, 10'h0, ra, rb);
    check("R6 clear by writing one", ra, 32'h0);
    @(negedge clk); #1;
    check("R6 irq drops after clear", 32'(irq_a), 32'h0);

    // R5: other enable bits set but bit 0 clear; trigger ignored.
    bus_cycle(1'b1, 1'b0, 1'b0, 8'h00, 32'hE, 10'h0, ra, rb);
    bus_cycle(1'b0, 1'b0, 1'b1, 8'h00, 32'h0, 10'h1EE, ra, rb);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h4C, 32'h0, 10'h0, ra, rb);
    check("R5 ignored with bit 0 clear", ra, exp_status());
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h04, 32'h0, 10'h0, ra, rb);
    check("R5 raw stays clear", ra, 32'h0);

    // R8: sequencer windows are distinct.
    bus_cycle(1'b1, 1'b0, 1'b0, 8'h60, 32'h1234_5678, 10'h0, ra, rb);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h60, 32'h0, 10'h0, ra, rb);
    check("R8 R7 sequencer 1 mux", ra, 32'h1230_1230);
    bus_cycle(1'b1, 1'b0, 1'b0, 8'hA4, 32'hCAFE_F00D, 10'h0, ra, rb);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'hA4, 32'h0, 10'h0, ra, rb);
    check("R8 R7 sequencer 3 control", ra, 32'hCAFE_F00D);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h84, 32'h0, 10'h0, ra, rb);
    check("R8 sequencer 2 control untouched", ra, 32'h0);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h40, 32'h0, 10'h0, ra, rb);
    check("R8 sequencer 0 mux kept", ra, 32'h3333_3333);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'hAC, 32'h0, 10'h0, ra, rb);
    check("R8 sequencer 3 status", ra, 32'h100);

    // R1: reset in mid-run.
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h4C, 32'h0, 10'h0, ra, rb);
    check("R1 status after reset", ra, 32'h100);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'hA4, 32'h0, 10'h0, ra, rb);
    check("R1 control after reset", ra, 32'h0);
    bus_cycle(1'b0, 1'b1, 1'b0, 8'h00, 32'h0, 10'h0, ra, rb);
    check("R1 enable after reset", ra, 32'h0);

    finish_report();
  end

endmodule